// File: doc/BRIEF.md
# ADC Trigger and Result Controller

This block is the digital control front end of a 10-bit analog-to-digital converter inside a microcontroller. Software reaches it through a small byte-wide register port. A control byte sets the module enable, a start/busy flag, a 4-bit input channel, a reference choice and the justification of the result. A secondary byte holds a 3-bit conversion clock select. Two read-only bytes hold the packed result, and a status byte holds the conversion-complete interrupt flag.

A conversion starts in one of two ways. Software can set the start/busy flag, or a compare unit can raise a special-event trigger while its mode field selects the event mode. Either way the block issues a one-cycle start strobe to an external converter engine. The engine later pulses a done signal with a 10-bit code. The block then packs the code into the two result bytes, clears the busy flag and raises the interrupt flag. A qualifying special event always clears the shared 16-bit timer that this block keeps, even when the converter is disabled. A reset aborts any conversion in progress and leaves the result bytes as they were.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, the control byte (address 0), the secondary byte (address 1), the status byte (address 4), conv_start and irq_flag all read 0. Addresses 5 to 7 always read 0.
- R2: Control byte bit layout: bit 7 = format (1 = right justified), bit 6 = reference select, bits 5:2 = channel, bit 1 = start/busy, bit 0 = enable. A write stores the fields, reads back unchanged, and drives adc_vref and adc_chan.
- R3: The secondary byte (address 1) stores bits 6:4 as clk_sel. All other bits of that byte read 0.
- R4: While idle, a control write with bits 1 and 0 both set makes busy read 1 and pulses conv_start for exactly one cycle. This happens in the same cycle that busy first reads 1.
- R5: A control write that sets bit 1 while a conversion is running gives no new conv_start pulse, and busy stays 1.
- R6: A special event (evt_trig high with evt_mode = 4'b1011) while enabled and idle sets busy and pulses conv_start one cycle later.
- R7: tmr_count advances by one every clock. It reads 0 the cycle after a special event with evt_mode = 4'b1011, whether or not the module is enabled. Events with any other mode do not clear it.
- R8: A special event with the enable bit clear, or with evt_mode other than 4'b1011, starts nothing: busy stays 0 and conv_start stays 0.
- R9: conv_done while busy writes both result bytes in one cycle, clears busy and sets irq_flag. conv_done while idle changes neither result byte nor irq_flag.
- R10: Left justified (format 0): high byte (address 2) = code[9:2], low byte (address 3) = {code[1:0], 6'b0}. Right justified (format 1): high byte = {6'b0, code[9:8]}, low byte = code[7:0].
- R11: Writing the status byte (address 4) with bit 0 = 0 clears irq_flag. Writing it with bit 0 = 1 leaves irq_flag unchanged. irq_flag reads back in bit 0 of that byte.
- R12: Reset during a conversion clears busy and aborts the conversion, so a later conv_done is ignored. Reset does not change the result bytes.
- R13: A control write that clears bit 1 or bit 0 while busy aborts the conversion, and a later conv_done is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| evt_trig | input | 1 | Special-event pulse from the compare unit |
| evt_mode | input | 4 | Compare unit mode field |
| tmr_count | output | 16 | Shared timer count |
| conv_start | output | 1 | One-cycle start strobe to the engine |
| conv_done | input | 1 | Engine completion pulse |
| conv_code | input | 10 | Engine result code, valid with conv_done |
| adc_chan | output | 4 | Selected input channel |
| adc_vref | output | 1 | Selected reference |
| clk_sel | output | 3 | Conversion clock select |
| irq_flag | output | 1 | Conversion-complete interrupt flag |

## Verification
The assertions check several rules on every cycle. A start strobe is always a single pulse, and it only appears while the module is enabled and busy. Busy holds until a done pulse or a control write. A done pulse always clears busy and raises the flag. A disabled event never sets busy. A qualifying event always zeroes the timer. The bench scenarios cover what the properties cannot show alone: the exact bit packing in both justifications, and that results survive a reset. They also show that done pulses after an abort or a reset are ignored, and that the read-back layout and unimplemented bits match the register map.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
   localparam logic [2:0] ADR_CTRL = 3'd0;
   localparam logic [2:0] ADR_AUX  = 3'd1;
   localparam logic [2:0] ADR_HI   = 3'd2;
   localparam logic [2:0] ADR_LO   = 3'd3;
   localparam logic [2:0] ADR_STAT = 3'd4;

   typedef struct packed {
      logic       fmt_right;
      logic       vref;
      logic [3:0] chan;
      logic       busy;
      logic       en;
   } ctrl_t;
endpackage

// File: rtl/adc_evt_timer.sv
module adc_evt_timer #(
   parameter int TMR_W = 16,
   parameter int MODE_W = 4,
   parameter logic [MODE_W-1:0] TRIG_MODE = 4'b1011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_trig,
   input  logic [MODE_W-1:0] evt_mode,
   output logic              trig_hit,
   output logic [TMR_W-1:0]  tmr_count
);
   generate
      if (TMR_W < 2) begin : g_bad_tmr
         $error("adc_evt_timer: TMR_W must be at least 2");
      end
   endgenerate

   assign trig_hit = evt_trig && (evt_mode == TRIG_MODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tmr_count <= '0;
      else if (trig_hit) tmr_count <= '0;
      else               tmr_count <= tmr_count + 1'b1;
   end

   // R7: any other mode lets the timer keep counting
   a_r7_other_mode_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_trig && evt_mode != TRIG_MODE) |=> tmr_count == $past(tmr_count) + 1'b1);
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs
   import adc_ctrl_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int CSEL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              trig_hit,
   input  logic              conv_done,
   output ctrl_t             ctrl_q,
   output logic [CSEL_W-1:0] clk_sel,
   output logic              irq_q,
   output logic              conv_start,
   output logic              done_acc
);
   localparam int CSEL_LSB = 4;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("adc_ctl_regs: ADDR_W must be at least 3");
      end
      if (CSEL_LSB + CSEL_W > 7) begin : g_bad_csel
         $error("adc_ctl_regs: clock select does not fit bits 6:4");
      end
   endgenerate

   logic  wr_ctrl, wr_aux, wr_stat, start_now;
   ctrl_t ctrl_n;

   assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(ADR_CTRL));
   assign wr_aux   = bus_we && (bus_addr == ADDR_W'(ADR_AUX));
   assign wr_stat  = bus_we && (bus_addr == ADDR_W'(ADR_STAT));
   assign done_acc = conv_done && ctrl_q.busy;

   always_comb begin
      ctrl_n    = ctrl_q;
      start_now = 1'b0;
      if (wr_ctrl) begin
         ctrl_n      = ctrl_t'(bus_wdata);
         ctrl_n.busy = bus_wdata[1] && bus_wdata[0];
         start_now   = bus_wdata[1] && bus_wdata[0] && !ctrl_q.busy;
      end else if (trig_hit && ctrl_q.en && !ctrl_q.busy) begin
         ctrl_n.busy = 1'b1;
         start_now   = 1'b1;
      end
      if (done_acc) ctrl_n.busy = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         clk_sel    <= '0;
         irq_q      <= 1'b0;
         conv_start <= 1'b0;
      end else begin
         ctrl_q     <= ctrl_n;
         conv_start <= start_now;
         if (wr_aux) clk_sel <= bus_wdata[CSEL_LSB +: CSEL_W];
         if (done_acc)                     irq_q <= 1'b1;
         else if (wr_stat && !bus_wdata[0]) irq_q <= 1'b0;
      end
   end

   // R4: a start strobe only while enabled and busy, one cycle wide
   a_r4_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> (ctrl_q.busy && ctrl_q.en));
   a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   // R5: busy holds until done or a control write
   a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.busy && !conv_done && !wr_ctrl) |=> ctrl_q.busy);
   // R8: a disabled event never sets busy
   a_r8_disabled_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_hit && !ctrl_q.en && !ctrl_q.busy && !wr_ctrl) |=> !ctrl_q.busy);
   // R9: completion clears busy and raises the flag
   a_r9_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && ctrl_q.busy) |=> (irq_q && !ctrl_q.busy));
endmodule

// File: rtl/adc_result_pack.sv
module adc_result_pack #(
   parameter int CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              fmt_right,
   input  logic [CODE_W-1:0] code,
   output logic [7:0]        res_hi,
   output logic [7:0]        res_lo
);
   localparam int PAIR_W = 16;
   localparam int PAD_W  = PAIR_W - CODE_W;

   generate
      if (CODE_W < 9 || CODE_W > PAIR_W) begin : g_bad_code
         $error("adc_result_pack: CODE_W must be 9..16");
      end
   endgenerate

   logic [PAIR_W-1:0] left_j, right_j, packed_v;

   assign right_j  = PAIR_W'(code);
   assign left_j   = right_j << PAD_W;
   assign packed_v = fmt_right ? right_j : left_j;

   // result bytes have no reset: they survive device reset
   always_ff @(posedge clk) begin
      if (capture) {res_hi, res_lo} <= packed_v;
   end

   // R10: unused positions of a left-justified result stay zero
   a_r10_left_pad: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !fmt_right) |=> res_lo[PAD_W-1:0] == '0);
   // R10: unused positions of a right-justified result stay zero
   a_r10_right_pad: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && fmt_right) |=> res_hi[7:CODE_W-8] == '0);
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
   import adc_ctrl_pkg::*;
#(
   parameter int CODE_W = 10,
   parameter int TMR_W = 16,
   parameter int ADDR_W = 3,
   parameter int MODE_W = 4,
   parameter int CHAN_W = 4,
   parameter int CSEL_W = 3,
   parameter logic [MODE_W-1:0] TRIG_MODE = 4'b1011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              evt_trig,
   input  logic [MODE_W-1:0] evt_mode,
   output logic [TMR_W-1:0]  tmr_count,
   output logic              conv_start,
   input  logic              conv_done,
   input  logic [CODE_W-1:0] conv_code,
   output logic [CHAN_W-1:0] adc_chan,
   output logic              adc_vref,
   output logic [CSEL_W-1:0] clk_sel,
   output logic              irq_flag
);
   generate
      if (CHAN_W != 4) begin : g_bad_chan
         $error("adc_trig_ctrl: CHAN_W must be 4 to fit the control byte");
      end
   endgenerate

   ctrl_t      ctrl_q;
   logic       trig_hit, done_acc;
   logic [7:0] res_hi, res_lo;

   adc_evt_timer #(.TMR_W(TMR_W), .MODE_W(MODE_W), .TRIG_MODE(TRIG_MODE)) u_tmr (
      .clk(clk), .rst_n(rst_n), .evt_trig(evt_trig), .evt_mode(evt_mode),
      .trig_hit(trig_hit), .tmr_count(tmr_count));

   adc_ctl_regs #(.ADDR_W(ADDR_W), .CSEL_W(CSEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .trig_hit(trig_hit), .conv_done(conv_done),
      .ctrl_q(ctrl_q), .clk_sel(clk_sel), .irq_q(irq_flag),
      .conv_start(conv_start), .done_acc(done_acc));

   adc_result_pack #(.CODE_W(CODE_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .capture(done_acc), .fmt_right(ctrl_q.fmt_right),
      .code(conv_code), .res_hi(res_hi), .res_lo(res_lo));

   assign adc_chan = ctrl_q.chan;
   assign adc_vref = ctrl_q.vref;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADR_CTRL))      bus_rdata = ctrl_q;
      else if (bus_addr == ADDR_W'(ADR_AUX))  bus_rdata[4 +: CSEL_W] = clk_sel;
      else if (bus_addr == ADDR_W'(ADR_HI))   bus_rdata = res_hi;
      else if (bus_addr == ADDR_W'(ADR_LO))   bus_rdata = res_lo;
      else if (bus_addr == ADDR_W'(ADR_STAT)) bus_rdata[0] = irq_flag;
   end

   // R7: a qualifying event zeroes the timer whatever the enable
   a_r7_event_clears_tmr: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_trig && evt_mode == TRIG_MODE) |=> tmr_count == '0);
   // R6: an enabled idle event leads to a start strobe
   a_r6_event_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_trig && evt_mode == TRIG_MODE && ctrl_q.en && !ctrl_q.busy && !bus_we)
      |=> conv_start);
endmodule

// File: tb/tb_adc_trig_ctrl.sv
module tb_adc_trig_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        evt_trig = 1'b0;
   logic [3:0]  evt_mode = '0;
   logic [15:0] tmr_count;
   logic        conv_start;
   logic        conv_done = 1'b0;
   logic [9:0]  conv_code = '0;
   logic [3:0]  adc_chan;
   logic        adc_vref;
   logic [2:0]  clk_sel;
   logic        irq_flag;

   localparam int CONV_CLKS = 11;
   int n_checks = 0, n_fail = 0, cyc = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   adc_trig_ctrl dut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; #1 d = bus_rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string req);
      logic [7:0] d;
      rd(a, d);
      chk(d == e, req, d, e);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic engine_done(input logic [9:0] code);
      repeat (CONV_CLKS) @(negedge clk);
      conv_done = 1'b1; conv_code = code;
      @(negedge clk); conv_done = 1'b0;
   endtask

   task automatic pulse_evt(input logic [3:0] m);
      @(negedge clk); evt_trig = 1'b1; evt_mode = m;
      @(negedge clk); evt_trig = 1'b0;
   endtask

   task automatic t_reset_state();
      chk(conv_start == 1'b0, "R1 conv_start", conv_start, 0);
      chk(irq_flag == 1'b0, "R1 irq_flag", irq_flag, 0);
      rd_chk(3'd0, 8'h00, "R1 ctrl");
      rd_chk(3'd1, 8'h00, "R1 aux");
      rd_chk(3'd4, 8'h00, "R1 status");
      rd_chk(3'd6, 8'h00, "R1 unused address");
   endtask

   task automatic t_fields();
      wr(3'd0, 8'h68);
      chk(conv_start == 1'b0, "R2 no start", conv_start, 0);
      chk(adc_chan == 4'hA, "R2 adc_chan", adc_chan, 4'hA);
      chk(adc_vref == 1'b1, "R2 adc_vref", adc_vref, 1);
      rd_chk(3'd0, 8'h68, "R2 readback");
      wr(3'd1, 8'hFF);
      chk(clk_sel == 3'd7, "R3 clk_sel", clk_sel, 7);
      rd_chk(3'd1, 8'h70, "R3 unimplemented bits");
      wr(3'd1, 8'h20);
      chk(clk_sel == 3'd2, "R3 clk_sel value", clk_sel, 2);
   endtask

   task automatic t_sw_start_left();
      wr(3'd0, 8'h03);
      chk(conv_start == 1'b1, "R4 start pulse", conv_start, 1);
      @(negedge clk);
      chk(conv_start == 1'b0, "R4 pulse width", conv_start, 0);
      wr(3'd0, 8'h03);
      chk(conv_start == 1'b0, "R5 no restart", conv_start, 0);
      rd_chk(3'd0, 8'h03, "R5 still busy");
      engine_done(10'h2D6);
      chk(irq_flag == 1'b1, "R9 irq set", irq_flag, 1);
      rd_chk(3'd0, 8'h01, "R9 busy cleared");
      rd_chk(3'd2, 8'hB5, "R10 left high");
      rd_chk(3'd3, 8'h80, "R10 left low");
   endtask

   task automatic t_irq_clear();
      wr(3'd4, 8'h01);
      chk(irq_flag == 1'b1, "R11 write 1 keeps", irq_flag, 1);
      wr(3'd4, 8'h00);
      chk(irq_flag == 1'b0, "R11 write 0 clears", irq_flag, 0);
      rd_chk(3'd4, 8'h00, "R11 status readback");
   endtask

   task automatic t_right_and_idle_done();
      wr(3'd0, 8'h83);
      engine_done(10'h13C);
      rd_chk(3'd2, 8'h01, "R10 right high");
      rd_chk(3'd3, 8'h3C, "R10 right low");
      wr(3'd4, 8'h00);
      engine_done(10'h2D6);
      chk(irq_flag == 1'b0, "R9 idle done no irq", irq_flag, 0);
      rd_chk(3'd3, 8'h3C, "R9 idle done no write");
   endtask

   task automatic t_event_enabled();
      logic [15:0] c0;
      wr(3'd0, 8'h01);
      repeat (5) @(negedge clk);
      pulse_evt(4'b1011);
      chk(tmr_count == 16'd0, "R7 timer cleared", tmr_count, 0);
      chk(conv_start == 1'b1, "R6 event start", conv_start, 1);
      rd_chk(3'd0, 8'h03, "R6 busy set");
      chk(tmr_count == 16'd1, "R7 timer counts", tmr_count, 1);
      engine_done(10'h2D6);
      rd_chk(3'd2, 8'hB5, "R6 result high");
      wr(3'd4, 8'h00);
      @(negedge clk); c0 = tmr_count;
      evt_trig = 1'b1; evt_mode = 4'b1010;
      @(negedge clk); evt_trig = 1'b0;
      chk(tmr_count == c0 + 16'd1, "R7 other mode no clear", tmr_count, c0 + 16'd1);
      chk(conv_start == 1'b0, "R8 other mode no start", conv_start, 0);
      rd_chk(3'd0, 8'h01, "R8 other mode idle");
   endtask

   task automatic t_event_disabled();
      wr(3'd0, 8'h00);
      repeat (4) @(negedge clk);
      pulse_evt(4'b1011);
      chk(tmr_count == 16'd0, "R7 cleared while disabled", tmr_count, 0);
      chk(conv_start == 1'b0, "R8 disabled no start", conv_start, 0);
      rd_chk(3'd0, 8'h00, "R8 disabled not busy");
   endtask

   task automatic t_abort_write();
      wr(3'd0, 8'h03);
      wr(3'd0, 8'h01);
      rd_chk(3'd0, 8'h01, "R13 abort clears busy");
      engine_done(10'h13C);
      chk(irq_flag == 1'b0, "R13 done ignored", irq_flag, 0);
      rd_chk(3'd2, 8'hB5, "R13 result kept");
   endtask

   task automatic t_reset_abort();
      wr(3'd0, 8'h83);
      do_reset();
      rd_chk(3'd0, 8'h00, "R12 ctrl cleared");
      engine_done(10'h13C);
      chk(irq_flag == 1'b0, "R12 done ignored", irq_flag, 0);
      rd_chk(3'd2, 8'hB5, "R12 high kept");
      rd_chk(3'd3, 8'h80, "R12 low kept");
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         finish_run();
      end
   end

   initial begin
      do_reset();
      t_reset_state();
      t_fields();
      t_sw_start_left();
      t_irq_clear();
      t_right_and_idle_done();
      t_event_enabled();
      t_event_disabled();
      wr(3'd0, 8'h01);
      engine_done(10'h2D6);
      wr(3'd0, 8'h03);
      engine_done(10'h2D6);
      wr(3'd4, 8'h00);
      t_abort_write();
      t_reset_abort();
      finish_run();
   end
endmodule